// File: doc/BRIEF.md
# Multi-Lane Serial Flash Transfer Engine

This block is a software-driven host for serial memories. A processor configures it through a small 32-bit register bus. It then writes bytes to one of four transmit ports, and the block clocks those bytes out over 1, 2, 4 or 8 I/O lanes. The number of bytes in a write (1 to 4) is set by which port address the processor uses. Every transmit word also captures a receive word of the same length, which the processor reads back from a single receive port.

A per-operation setup register splits the byte stream that follows chip-select assertion into phases: command, address, dummy and data. Each phase has its own lane width. When the setup marks the data phase as a read, the block releases the data lanes so that the memory can drive them. Chip select is either held by software through the configuration register or driven automatically while a word is in flight. Clock polarity and phase are selectable, which gives the four usual SPI modes. Clearing the enable register stops everything at once.

Top module: `mlf_host`

## Requirements
- R1: Word offsets 4..7 are transmit ports. Writing offset 4+n sends n bytes for n = 1..3, and writing offset 4 sends 4 bytes. Bytes leave in order wdata[7:0] first. A write is accepted only while enabled and while no word is pending.
- R2: Each transmit word produces one receive word at offset 8. Byte k of an n-byte word lands at bits [8*(4-n+k)+7 : 8*(4-n+k)], which keeps the valid bytes at the most significant end. The rest of the word is zero.
- R3: Status at offset 1 gives bit 0 = transmit empty (nothing pending or shifting), bit 1 = transmit not full, bit 2 = receive not empty and bit 3 = receive not full. Reading the receive port empties it.
- R4: Lane codes 0/1/2/3 mean 1/2/4/8 lanes. The setup register at offset 3 holds the command code in [1:0], the address code in [4:3], the data code in [7:6], command bytes minus one in bit 13, address bytes in [16:14], dummy bytes in [22:17] and read direction in bit 23. Bytes counted from chip-select assertion use the command width first, then the address width, then the data width (dummy and data).
- R5: A byte takes 8, 4, 2 or 1 serial clocks. Its bits go out most significant first, and the highest used lane carries the most significant bit of each group.
- R6: In single-lane mode lane 1 is an input and receive bits are taken from it. In a read data phase of 2 or more lanes, those lanes are released and sampled.
- R7: With config bit 1 set, chip select (active low) follows config bit 0. With bit 1 clear, it is asserted only while a word is pending or shifting. Deasserting it stops the shifter.
- R8: Lanes that carry no payload are driven to the level in config bit 16, which is set after reset.
- R9: Config bit 19 sets the idle level of the serial clock, and bit 20 moves sampling to the trailing edge.
- R10: Clearing bit 0 of the enable register at offset 2 aborts shifting, deasserts chip select and empties both buffers.
- R11: After reset: status 0xB, chip select high, serial clock low, all lanes high, receive word zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_o | output | 8 | Lane output values |
| io_oe | output | 8 | Lane output enables |
| io_i | input | 8 | Lane input values |

## Verification
The bench walks every port length and every lane width, and compares the clocked-out bit stream with the written bytes. If the byte order or the lane mapping were wrong, that stream would come out reversed or permuted. A short word whose receive bytes sat at the low end instead of the high end fails the alignment check. A stream with mixed widths counts serial edges, so a design that applied one width to every phase would produce the wrong count. The bench also checks the lane release in a read phase, the window between transmit-empty and receive-not-empty (a lag there would show as a wrong status), and an abort in mid-word that leaves chip select low or stale data behind.

// File: rtl/mlf_pkg.sv
package mlf_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 8;
    localparam int AW     = 4;
    localparam int IDX_W  = 8;

    localparam logic [AW-1:0] A_CFG  = 4'd0;
    localparam logic [AW-1:0] A_STAT = 4'd1;
    localparam logic [AW-1:0] A_EN   = 4'd2;
    localparam logic [AW-1:0] A_OP   = 4'd3;
    localparam logic [AW-1:0] A_TX0  = 4'd4;
    localparam logic [AW-1:0] A_RX   = 4'd8;

    localparam logic [WORD_W-1:0] CFG_MASK  = 32'h0019_0003;
    localparam logic [WORD_W-1:0] CFG_RESET = 32'h0001_0000;
    localparam logic [WORD_W-1:0] OP_MASK   = 32'h00FF_E0DB;

    typedef enum logic [1:0] {LW_1 = 2'd0, LW_2 = 2'd1, LW_4 = 2'd2, LW_8 = 2'd3} lane_code_e;

    typedef struct packed {
        logic cpha;
        logic cpol;
        logic idle_hi;
        logic cs_manual;
        logic cs_assert;
    } cfg_t;

    typedef struct packed {
        logic       rd_dir;
        logic [5:0] dummy_n;
        logic [2:0] adr_n;
        logic       cmd_two;
        lane_code_e dat_w;
        lane_code_e adr_w;
        lane_code_e cmd_w;
    } op_t;

    function automatic cfg_t cfg_unpack(logic [WORD_W-1:0] w);
        return '{cpha: w[20], cpol: w[19], idle_hi: w[16], cs_manual: w[1], cs_assert: w[0]};
    endfunction

    function automatic op_t op_unpack(logic [WORD_W-1:0] w);
        return '{rd_dir: w[23], dummy_n: w[22:17], adr_n: w[16:14], cmd_two: w[13],
                 dat_w: lane_code_e'(w[7:6]), adr_w: lane_code_e'(w[4:3]),
                 cmd_w: lane_code_e'(w[1:0])};
    endfunction

    function automatic logic [3:0] lane_count(lane_code_e c);
        return 4'd1 << c;
    endfunction

    function automatic logic [3:0] clocks_per_byte(lane_code_e c);
        return 4'd8 >> c;
    endfunction

    function automatic logic [IDX_W-1:0] addr_end(op_t op);
        return {7'd0, op.cmd_two} + 8'd1 + {5'd0, op.adr_n};
    endfunction

    function automatic lane_code_e byte_code(op_t op, logic [IDX_W-1:0] b);
        if (b < {7'd0, op.cmd_two} + 8'd1) return op.cmd_w;
        if (b < addr_end(op))                return op.adr_w;
        return op.dat_w;
    endfunction

    function automatic logic byte_is_rd(op_t op, logic [IDX_W-1:0] b);
        return op.rd_dir && (b >= addr_end(op) + {2'd0, op.dummy_n});
    endfunction
endpackage

// File: rtl/mlf_regs.sv
module mlf_regs
    import mlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] cfg_raw,
    output logic [WORD_W-1:0] op_raw,
    output logic              en,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic [2:0]        tx_nbytes,
    input  logic              tx_take,
    input  logic              eng_busy,
    input  logic              rx_done,
    input  logic [WORD_W-1:0] rx_word
);
    logic              rx_v_q;
    logic [WORD_W-1:0] rx_w_q;
    logic              is_tx;
    logic [3:0]        stat;

    assign is_tx = (bus_addr >= A_TX0) && (bus_addr < A_RX);
    assign stat  = {!rx_v_q, rx_v_q, !tx_valid, !tx_valid && !eng_busy && !rx_done};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_raw   <= CFG_RESET;
            op_raw    <= '0;
            en        <= 1'b0;
            tx_valid  <= 1'b0;
            tx_word   <= '0;
            tx_nbytes <= '0;
            rx_v_q    <= 1'b0;
            rx_w_q    <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CFG) cfg_raw <= bus_wdata & CFG_MASK;
            if (bus_wr && bus_addr == A_OP)  op_raw  <= bus_wdata & OP_MASK;
            if (bus_wr && bus_addr == A_EN)  en      <= bus_wdata[0];
            if (tx_take) tx_valid <= 1'b0;
            if (bus_wr && is_tx && en && !tx_valid) begin
                tx_valid  <= 1'b1;
                tx_word   <= bus_wdata;
                tx_nbytes <= (bus_addr[1:0] == 2'd0) ? 3'd4 : {1'b0, bus_addr[1:0]};
            end
            if (rx_done) begin
                rx_v_q <= 1'b1;
                rx_w_q <= rx_word;
            end else if (bus_rd && bus_addr == A_RX) begin
                rx_v_q <= 1'b0;
            end
            if (!en) begin
                tx_valid <= 1'b0;
                rx_v_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = cfg_raw;
            A_STAT:  bus_rdata = {28'd0, stat};
            A_EN:    bus_rdata = {31'd0, en};
            A_OP:    bus_rdata = op_raw;
            A_RX:    bus_rdata = rx_w_q;
            default: bus_rdata = '0;
        endcase
    end

    // R1
    tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_tx && en && !tx_valid) |=> tx_valid);

    // R3
    rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && en) |=> rx_v_q);
endmodule

// File: rtl/mlf_shifter.sv
module mlf_shifter
    import mlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              cs_live,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        nbytes,
    input  op_t               op,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              idle_hi,
    input  logic [LANES-1:0]  io_i,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic [LANES-1:0]  io_o,
    output logic [LANES-1:0]  io_oe
);
    logic              busy_q, done_q, half_q, first_q, rdph_q;
    logic [3:0]        clk_left_q;
    logic [2:0]        byte_left_q;
    logic [WORD_W-1:0] txw_q, rxw_q;
    logic [7:0]        sh_q, rxb_q, rx_next, in_bits, aligned;
    logic [IDX_W-1:0]  bidx_q;
    lane_code_e        code_q, nxt_code, oe_code;
    logic [3:0]        lanes;
    logic              sample_now, shift_now;

    assign lanes      = lane_count(code_q);
    assign sample_now = busy_q && (cpha ? half_q : !half_q);
    assign shift_now  = busy_q && (cpha ? (!half_q && !first_q) : half_q);
    assign in_bits    = (code_q == LW_1) ? {7'd0, io_i[1]} : (io_i & ((8'd1 << lanes) - 8'd1));
    assign rx_next    = sample_now ? ((rxb_q << lanes) | in_bits) : rxb_q;
    assign nxt_code   = byte_code(op, bidx_q + 8'd1);
    assign aligned    = sh_q >> (4'd8 - lanes);
    assign oe_code    = busy_q ? code_q : op.cmd_w;

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            busy_q <= 1'b0; half_q <= 1'b0; first_q <= 1'b0; rdph_q <= 1'b0;
            clk_left_q <= '0; byte_left_q <= '0; txw_q <= '0; rxw_q <= '0;
            sh_q <= '0; rxb_q <= '0; bidx_q <= '0; code_q <= LW_1;
        end else if (abort) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            if (!cs_live) bidx_q <= '0;
        end else if (start) begin
            busy_q      <= 1'b1;
            half_q      <= 1'b0;
            first_q     <= 1'b1;
            txw_q       <= word;
            sh_q        <= word[7:0];
            byte_left_q <= nbytes;
            code_q      <= byte_code(op, bidx_q);
            rdph_q      <= byte_is_rd(op, bidx_q);
            clk_left_q  <= clocks_per_byte(byte_code(op, bidx_q));
            rxb_q       <= '0;
            rxw_q       <= '0;
        end else if (busy_q) begin
            half_q <= !half_q;
            rxb_q  <= rx_next;
            if (!half_q)   first_q <= 1'b0;
            if (shift_now) sh_q <= sh_q << lanes;
            if (half_q) begin
                if (clk_left_q == 4'd1) begin
                    rxw_q  <= {rx_next, rxw_q[WORD_W-1:8]};
                    bidx_q <= bidx_q + 8'd1;
                    if (byte_left_q == 3'd1) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        byte_left_q <= byte_left_q - 3'd1;
                        txw_q       <= txw_q >> 8;
                        sh_q        <= txw_q[15:8];
                        code_q      <= nxt_code;
                        rdph_q      <= byte_is_rd(op, bidx_q + 8'd1);
                        clk_left_q  <= clocks_per_byte(nxt_code);
                        first_q     <= 1'b1;
                        rxb_q       <= '0;
                    end
                end else begin
                    clk_left_q <= clk_left_q - 4'd1;
                end
            end
        end
    end

    always_comb begin
        io_o  = {LANES{idle_hi}};
        io_oe = (oe_code == LW_1) ? ~8'h02 : 8'hFF;
        if (busy_q && !rdph_q) begin
            for (int k = 0; k < LANES; k++)
                if (k < int'(lanes)) io_o[k] = aligned[k];
        end
        if (busy_q && rdph_q && code_q != LW_1)
            io_oe = io_oe & ~((8'd1 << lanes) - 8'd1);
    end

    assign sclk    = busy_q ? (cpol ^ half_q) : cpol;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_word = rxw_q;

    // R5
    clk_left_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (clk_left_q != 4'd0 && clk_left_q <= 4'd8));

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q));
endmodule

// File: rtl/mlf_host.sv
module mlf_host
    import mlf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  io_o,
    output logic [LANES-1:0]  io_oe,
    input  logic [LANES-1:0]  io_i
);
    logic [WORD_W-1:0] cfg_raw, op_raw, tx_word, rx_word;
    logic              en, tx_valid, busy, done, cs_live, start;
    logic [2:0]        tx_nbytes;
    cfg_t              cfg;
    op_t               op;

    assign cfg     = cfg_unpack(cfg_raw);
    assign op      = op_unpack(op_raw);
    assign cs_live = en && (cfg.cs_manual ? cfg.cs_assert : (busy || tx_valid));
    assign start   = tx_valid && !busy && cs_live;
    assign cs_n    = !cs_live;

    mlf_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_raw(cfg_raw), .op_raw(op_raw),
        .en(en), .tx_valid(tx_valid), .tx_word(tx_word), .tx_nbytes(tx_nbytes),
        .tx_take(start), .eng_busy(busy), .rx_done(done), .rx_word(rx_word)
    );

    mlf_shifter u_shift (
        .clk(clk), .rst(rst), .abort(!cs_live), .cs_live(cs_live), .start(start),
        .word(tx_word), .nbytes(tx_nbytes), .op(op), .cpol(cfg.cpol), .cpha(cfg.cpha),
        .idle_hi(cfg.idle_hi), .io_i(io_i), .busy(busy), .done(done), .rx_word(rx_word),
        .sclk(sclk), .io_o(io_o), .io_oe(io_oe)
    );

    // R10
    abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |=> !busy);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> !busy);
endmodule

// File: tb/mlf_host_bench.sv
module mlf_host_bench;
    import mlf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, cs_n;
    logic [7:0]  io_o, io_oe;
    logic [7:0]  io_i = '0;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] C_AS = 32'h1, C_MAN = 32'h2, C_IDLE = 32'h1_0000;
    localparam logic [31:0] C_CPOL = 32'h8_0000, C_CPHA = 32'h10_0000;

    always #4 clk = ~clk;

    mlf_host u_mlf_host (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .cs_n(cs_n),
        .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
    );

    // bit collector on rising serial clock edges
    logic        col_clr = 1'b0;
    int          col_l = 1;
    logic [31:0] col;
    logic [7:0]  oe_and;
    int          edges;
    always @(posedge sclk or posedge col_clr) begin
        if (col_clr) begin
            col <= '0; oe_and <= 8'hFF; edges <= 0;
        end else begin
            col    <= (col << col_l) | {24'd0, io_o & ((8'd1 << col_l) - 8'd1)};
            oe_and <= oe_and & io_oe;
            edges  <= edges + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  w;
        logic [1:0]  port;
        logic [31:0] wd;
        logic [7:0]  pat;
        logic [31:0] rx;
        logic [31:0] col;
        logic [7:0]  edg;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{w: 2'd0, port: 2'd1, wd: 32'h0000_00A5, pat: 8'h02, rx: 32'hFF00_0000, col: 32'h0000_00A5, edg: 8'd8},
        '{w: 2'd0, port: 2'd0, wd: 32'h4433_2211, pat: 8'h00, rx: 32'h0000_0000, col: 32'h1122_3344, edg: 8'd32},
        '{w: 2'd1, port: 2'd2, wd: 32'h0000_C35A, pat: 8'h01, rx: 32'h5555_0000, col: 32'h0000_5AC3, edg: 8'd8},
        '{w: 2'd2, port: 2'd3, wd: 32'h0096_0FF0, pat: 8'h0A, rx: 32'hAAAA_AA00, col: 32'h00F0_0F96, edg: 8'd6},
        '{w: 2'd3, port: 2'd0, wd: 32'h8040_2010, pat: 8'h3C, rx: 32'h3C3C_3C3C, col: 32'h1020_4080, edg: 8'd4},
        '{w: 2'd3, port: 2'd1, wd: 32'hFFFF_FF7E, pat: 8'hC3, rx: 32'hC300_0000, col: 32'h0000_007E, edg: 8'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_col();
        col_clr = 1'b1; #1; col_clr = 1'b0;
    endtask

    task automatic wait_tx_empty();
        logic [31:0] s;
        for (int i = 0; i < 500; i++) begin
            rd(A_STAT, s);
            if (s[0]) break;
        end
    endtask

    task automatic open_cs(input logic [31:0] extra);
        wr(A_CFG, C_MAN | C_IDLE | extra);
        wr(A_CFG, C_MAN | C_AS | C_IDLE | extra);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 / R3 reset state
        rd(A_STAT, d); chk("R11 reset status", d, 32'hB);
        chk("R11 reset cs_n", {31'd0, cs_n}, 32'd1);
        chk("R11 reset sclk", {31'd0, sclk}, 32'd0);
        chk("R11 reset io_o", {24'd0, io_o}, 32'hFF);
        rd(A_RX, d); chk("R11 reset rx", d, 32'd0);

        // R10: writes while disabled are dropped
        open_cs(0);
        clear_col();
        wr(A_TX0, 32'h1234_5678);
        repeat (40) @(negedge clk);
        chk("R10 disabled no edges", edges, 0);
        rd(A_STAT, d); chk("R10 disabled status", d, 32'hB);

        wr(A_EN, 32'h1);

        // vector table: R1 R2 R3 R4 R5 R6
        foreach (VECS[i]) begin
            io_i  = VECS[i].pat;
            col_l = 1 << VECS[i].w;
            wr(A_OP, {26'd0, VECS[i].w, 1'b0, VECS[i].w, 1'b0, VECS[i].w});
            open_cs(0);
            clear_col();
            wr(A_TX0 + {2'd0, VECS[i].port}, VECS[i].wd);
            wait_tx_empty();
            rd(A_STAT, d); chk("R3 status after word", d, 32'h7);
            rd(A_RX, d);   chk("R2 rx alignment", d, VECS[i].rx);
            chk("R5 lane bit order", col, VECS[i].col);
            chk("R1 edge count", edges, {24'd0, VECS[i].edg});
            chk("R6 lane enables", {24'd0, oe_and}, (VECS[i].w == 2'd0) ? 32'hFD : 32'hFF);
            rd(A_STAT, d); chk("R3 status after pop", d, 32'hB);
        end

        // R4 mixed widths: 1 cmd byte x1, 2 addr bytes x4, 1 data byte x8
        io_i = 8'h5A;
        wr(A_OP, 32'h0000_80D0);
        open_cs(0);
        clear_col();
        wr(A_TX0, 32'hDEAD_BEEF);
        wait_tx_empty();
        chk("R4 mixed edges", edges, 13);
        rd(A_RX, d); chk("R4 mixed rx", d, 32'h5AAA_AAFF);

        // R6 read phase releases lanes
        io_i = 8'h0C;
        wr(A_OP, 32'h0080_0092);
        open_cs(0);
        clear_col();
        wr(A_TX0 + 4'd2, 32'h0000_FF0B);
        wait_tx_empty();
        chk("R6 read oe", {24'd0, oe_and}, 32'hF0);
        rd(A_RX, d); chk("R6 read rx", d, 32'hCCCC_0000);

        // R8 idle level
        wr(A_CFG, C_MAN);
        chk("R8 idle low", {24'd0, io_o}, 32'h00);
        wr(A_CFG, C_MAN | C_IDLE);
        chk("R8 idle high", {24'd0, io_o}, 32'hFF);

        // R7 manual and automatic chip select
        wr(A_CFG, C_MAN | C_AS | C_IDLE);
        chk("R7 manual assert", {31'd0, cs_n}, 32'd0);
        wr(A_CFG, C_MAN | C_IDLE);
        chk("R7 manual release", {31'd0, cs_n}, 32'd1);
        wr(A_OP, 32'h0);
        wr(A_CFG, C_IDLE);
        chk("R7 auto idle", {31'd0, cs_n}, 32'd1);
        wr(A_TX0, 32'h0102_0304);
        repeat (5) @(negedge clk);
        chk("R7 auto active", {31'd0, cs_n}, 32'd0);
        wait_tx_empty();
        chk("R7 auto done", {31'd0, cs_n}, 32'd1);
        rd(A_RX, d);

        // R9 mode 3
        io_i = 8'h02;
        col_l = 1;
        open_cs(C_CPOL | C_CPHA);
        chk("R9 sclk idle high", {31'd0, sclk}, 32'd1);
        clear_col();
        wr(A_TX0 + 4'd1, 32'h0000_00C3);
        wait_tx_empty();
        chk("R9 mode3 edges", edges, 8);
        rd(A_RX, d); chk("R9 mode3 rx", d, 32'hFF00_0000);

        // R10 abort mid-word
        open_cs(0);
        wr(A_TX0, 32'hCAFE_F00D);
        repeat (10) @(negedge clk);
        wr(A_EN, 32'h0);
        repeat (2) @(negedge clk);
        chk("R10 abort cs_n", {31'd0, cs_n}, 32'd1);
        chk("R10 abort sclk", {31'd0, sclk}, 32'd0);
        rd(A_STAT, d); chk("R10 abort status", d, 32'hB);
        wr(A_EN, 32'h1);
        rd(A_STAT, d); chk("R10 reenable status", d, 32'hB);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule